// File: doc/BRIEF.md
# DMA Request Router for Four Channels

This block sits between a set of peripheral request lines and four DMA channel engines. Software programs a control word for each channel and a global operation word, all through a small register window. The router checks every incoming request strobe against each channel's 4-bit resource code. For each channel that matches and is eligible, it sends a single-cycle start pulse that tells the engine to move one transfer unit.

Channels whose resource code marks auto-request mode do not wait for a strobe. They are started again each time their engine reports idle. A start that arrives while an engine is busy is held as one pending bit. That pulse is issued once the engine goes idle. The data movement is done by the engines and lies outside this block.

Top module: `dma_req_router`

## Requirements
- R1: After reset every stored control word and the global word read as zero, and `chan_start` is all zero.
- R2: Strobes start nothing unless bits 2:0 of the global word (offset 0x040) equal 3'b001; the other bits of that word do not affect gating.
- R3: A channel is eligible only while its control bit 0 (enable) is 1 and control bit 1 (end flag) is 0.
- R4: Strobe bit 0 (external) matches resource code 0x0, bit 1 (serial port A transmit empty) matches 0x8, bit 2 (serial port A receive full) matches 0x9, bit 3 (serial port B transmit empty) matches 0xA, bit 4 (serial port B receive full) matches 0xB; the resource code is control bits 11:8, and codes 0x1 to 0x3 match no strobe.
- R5: Strobe bit 5 (timer capture) matches every channel whose resource code is 0xC or higher.
- R6: A strobe held for one cycle gives exactly one start pulse, one cycle wide, in the cycle after the strobe.
- R7: A channel whose control bits 11:10 equal 2'b01 is started in every cycle that follows a cycle with its busy input low. No strobe is needed, but the R2 and R3 gating still applies.
- R8: When one strobe matches several channels, all of them pulse `chan_start` in the same cycle.
- R9: A channel never receives a start in the cycle after its busy input was high. A match during busy is kept as one pending start, however many strobes arrive, and that start is issued in the cycle after busy is first seen low.
- R10: The control word of channel n sits at offset 0x00C + 0x10*n and the global word at 0x040. `reg_rdata` returns the addressed stored word in the same cycle. Every other offset reads zero, and writes to those offsets are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_strobe | input | 6 | Peripheral request pulses, bit meanings in R4 and R5 |
| chan_busy | input | 4 | Per-channel engine busy |
| chan_start | output | 4 | Per-channel one-unit start pulse |

## Verification
Two kinds of start can fall on a channel in the same cycle: a fresh strobe match and a pending start being released. Separately, several channels can match one strobe. The bench holds a channel busy while it sends repeated strobes. It then drops busy and expects exactly one pulse, followed by silence. The bench also sends one timer strobe to three channels with high codes and one channel with a serial-port code, and expects the three timer channels to pulse together while the fourth stays low.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
    localparam int NCH      = 4;
    localparam int CH_W     = $clog2(NCH);
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 4;
    localparam int NREQ     = 6;
    localparam int STRIDE_SH = 4;              // 0x10 per channel group
    localparam int CODE_LSB = 8;
    localparam logic [ADDR_W-1:0] GBL_OFS = 12'h040;
    localparam logic [STRIDE_SH-1:0] CTL_SUB = 4'hC;
    localparam logic [2:0] GBL_RUN = 3'b001;

    typedef enum int {
        RQ_EXT     = 0,
        RQ_SA_TXE  = 1,
        RQ_SA_RXF  = 2,
        RQ_SB_TXE  = 3,
        RQ_SB_RXF  = 4,
        RQ_TIMER   = 5
    } req_idx_e;

    function automatic logic code_hit(input logic [CODE_W-1:0] code,
                                      input logic [NREQ-1:0] rq);
        logic h;
        h = (rq[RQ_EXT]    && code == 4'h0) ||
            (rq[RQ_SA_TXE] && code == 4'h8) ||
            (rq[RQ_SA_RXF] && code == 4'h9) ||
            (rq[RQ_SB_TXE] && code == 4'hA) ||
            (rq[RQ_SB_RXF] && code == 4'hB) ||
            (rq[RQ_TIMER]  && code >= 4'hC);
        return h;
    endfunction

    function automatic logic is_auto(input logic [CODE_W-1:0] code);
        return code[CODE_W-1:CODE_W-2] == 2'b01;
    endfunction
endpackage

// File: rtl/dmar_regfile.sv
module dmar_regfile
    import dmar_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [N-1:0][CODE_W-1:0]     ch_code,
    output logic [N-1:0]                 ch_en,
    output logic [N-1:0]                 ch_end,
    output logic                         gbl_on
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam int HI = STRIDE_SH + CW;

    logic [N-1:0][DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0]        gbl_q;
    logic                     ctl_sel;
    logic [CW-1:0]            ctl_idx;
    logic                     gbl_sel;

    assign ctl_idx = addr[STRIDE_SH +: CW];
    assign ctl_sel = (addr[ADDR_W-1:HI] == '0) &&
                     (addr[STRIDE_SH-1:0] == CTL_SUB) &&
                     (int'(ctl_idx) < N);
    assign gbl_sel = (addr == GBL_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            gbl_q <= '0;
        end else if (wr_en) begin
            if (gbl_sel)
                gbl_q <= wdata;
            else if (ctl_sel)
                ctl_q[ctl_idx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (gbl_sel)
            rdata = gbl_q;
        else if (ctl_sel)
            rdata = ctl_q[ctl_idx];
    end

    for (genvar g = 0; g < N; g++) begin : g_fields
        assign ch_code[g] = ctl_q[g][CODE_LSB +: CODE_W];
        assign ch_en[g]   = ctl_q[g][0];
        assign ch_end[g]  = ctl_q[g][1];
    end

    assign gbl_on = (gbl_q[2:0] == GBL_RUN);
endmodule

// File: rtl/dmar_chan_route.sv
module dmar_chan_route
    import dmar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              enable,
    input  logic              end_flag,
    input  logic              gbl_on,
    input  logic [NREQ-1:0]   req,
    input  logic              busy,
    output logic              start,
    output logic              pending
);
    logic eligible;
    logic hit;
    logic want;
    logic start_q;
    logic pend_q;

    assign eligible = gbl_on && enable && !end_flag;
    assign hit      = eligible && (is_auto(code) || code_hit(code, req));
    assign want     = hit || pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            start_q <= want && !busy;
            pend_q  <= want && busy;
        end
    end

    assign start   = start_q;
    assign pending = pend_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
    import dmar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [5:0]        req_strobe,
    input  logic [3:0]        chan_busy,
    output logic [3:0]        chan_start
);
    logic [NCH-1:0][CODE_W-1:0] ch_code;
    logic [NCH-1:0]             ch_en;
    logic [NCH-1:0]             ch_end;
    logic                       gbl_on;
    logic [NCH-1:0]             pend_w;

    dmar_regfile #(.N(NCH)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ch_code (ch_code),
        .ch_en   (ch_en),
        .ch_end  (ch_end),
        .gbl_on  (gbl_on)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dmar_chan_route i_route (
            .clk      (clk),
            .rst      (rst),
            .code     (ch_code[c]),
            .enable   (ch_en[c]),
            .end_flag (ch_end[c]),
            .gbl_on   (gbl_on),
            .req      (req_strobe),
            .busy     (chan_busy[c]),
            .start    (chan_start[c]),
            .pending  (pend_w[c])
        );
    end
endmodule

// File: rtl/dmar_checker.sv
module dmar_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  chan_start,
    input logic [3:0]  chan_busy,
    input logic [3:0]  pend,
    input logic        gbl_on,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_rdata
);
    logic unmapped;
    assign unmapped = (reg_addr != 12'h040) &&
                      !((reg_addr[11:6] == 6'd0) && (reg_addr[3:0] == 4'hC));

    AST_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((chan_start & $past(chan_busy)) == 4'd0)); // R9

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend & chan_busy) & ~pend) == 4'd0)); // R9

    AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend & ~chan_busy) & ~chan_start) == 4'd0)); // R9

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        (!gbl_on && pend == 4'd0) |=> (chan_start == 4'd0)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (reg_rdata == 32'd0)); // R10
endmodule

bind dma_req_router dmar_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_start (chan_start),
    .chan_busy  (chan_busy),
    .pend       (pend_w),
    .gbl_on     (gbl_on),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/test_dma_req_router.sv
module test_dma_req_router;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  req_strobe = '0;
    logic [3:0]  chan_busy = '0;
    logic [3:0]  chan_start;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_router i_dma_req_router (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .req_strobe (req_strobe),
        .chan_busy  (chan_busy),
        .chan_start (chan_start)
    );

    // {code[10:7], strobe[6:1], expect start on channel 0 [0]}
    localparam int NV = 13;
    localparam logic [10:0] VEC [NV] = '{
        {4'h0, 6'b000001, 1'b1},   // R4 external
        {4'h0, 6'b000010, 1'b0},   // R4 wrong strobe
        {4'h8, 6'b000010, 1'b1},   // R4
        {4'h9, 6'b000100, 1'b1},   // R4
        {4'hA, 6'b001000, 1'b1},   // R4
        {4'hB, 6'b010000, 1'b1},   // R4
        {4'hB, 6'b001000, 1'b0},   // R4
        {4'h9, 6'b000010, 1'b0},   // R4
        {4'h2, 6'b000001, 1'b0},   // R4 code 2 matches nothing
        {4'hC, 6'b100000, 1'b1},   // R5
        {4'hD, 6'b100000, 1'b1},   // R5
        {4'hF, 6'b100000, 1'b1},   // R5
        {4'h3, 6'b100000, 1'b0}    // R5 below 0xC
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a,
                            input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, "readback", reg_rdata, exp);
    endtask

    task automatic pulse(input logic [5:0] s);
        // called at a negedge
        req_strobe = s;
        @(posedge clk); #1;
        @(negedge clk);
        req_strobe = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1 check("R1", "start after reset", {28'd0, chan_start}, 32'd0);
        rd_check("R1", 12'h00C, 32'd0);
        rd_check("R1", 12'h040, 32'd0);

        // R10 map and readback
        wr(12'h040, 32'h0000_0001);
        wr(12'h01C, 32'h0000_0A01);
        rd_check("R10", 12'h01C, 32'h0000_0A01);
        rd_check("R10", 12'h040, 32'h0000_0001);
        wr(12'h010, 32'hFFFF_FFFF);
        rd_check("R10", 12'h010, 32'd0);
        rd_check("R10", 12'h050, 32'd0);
        rd_check("R10", 12'h01C, 32'h0000_0A01);
        wr(12'h01C, 32'd0);

        // table walk on channel 0: R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            wr(12'h00C, {20'd0, VEC[v][10:7], 8'h01});
            req_strobe = VEC[v][6:1];
            @(posedge clk); #1;
            check(VEC[v][10:7] >= 4'hC || VEC[v][6:1] == 6'b100000 ? "R5" : "R4",
                  $sformatf("vector %0d start", v), {31'd0, chan_start[0]},
                  {31'd0, VEC[v][0]});
            @(negedge clk) req_strobe = '0;
            @(posedge clk); #1;
            check("R6", $sformatf("vector %0d single pulse", v),
                  {28'd0, chan_start}, 32'd0);
        end

        // R2 global gating
        wr(12'h00C, 32'h0000_0001);
        wr(12'h040, 32'h0000_0003);
        req_strobe = 6'b000001;
        @(posedge clk); #1 check("R2", "global 011 blocks", {28'd0, chan_start}, 32'd0);
        @(negedge clk) req_strobe = '0;
        wr(12'h040, 32'h0000_0009);
        req_strobe = 6'b000001;
        @(posedge clk); #1 check("R2", "global 1001 runs", {28'd0, chan_start}, 32'd1);
        @(negedge clk) req_strobe = '0;

        // R3 eligibility
        wr(12'h00C, 32'h0000_0003);
        req_strobe = 6'b000001;
        @(posedge clk); #1 check("R3", "end flag blocks", {28'd0, chan_start}, 32'd0);
        @(negedge clk) req_strobe = '0;
        wr(12'h00C, 32'h0000_0000);
        req_strobe = 6'b000001;
        @(posedge clk); #1 check("R3", "disabled blocks", {28'd0, chan_start}, 32'd0);
        @(negedge clk) req_strobe = '0;

        // R8 simultaneous starts
        wr(12'h00C, 32'h0000_0C01);
        wr(12'h01C, 32'h0000_0E01);
        wr(12'h02C, 32'h0000_0D01);
        wr(12'h03C, 32'h0000_0801);
        req_strobe = 6'b100000;
        @(posedge clk); #1 check("R8", "timer fan-out", {28'd0, chan_start}, 32'h7);
        @(negedge clk) req_strobe = '0;
        @(posedge clk); #1 check("R8", "fan-out ends", {28'd0, chan_start}, 32'd0);
        wr(12'h00C, 32'd0); wr(12'h01C, 32'd0); wr(12'h02C, 32'd0); wr(12'h03C, 32'd0);

        // R7 auto-request
        wr(12'h01C, 32'h0000_0401);
        @(posedge clk); #1 check("R7", "auto start 1", {28'd0, chan_start}, 32'h2);
        @(posedge clk); #1 check("R7", "auto start 2", {28'd0, chan_start}, 32'h2);
        @(negedge clk) chan_busy = 4'h2;
        @(posedge clk); #1 check("R7", "auto held by busy", {28'd0, chan_start}, 32'd0);
        wr(12'h040, 32'h0000_0000);
        @(negedge clk) chan_busy = 4'h0;
        @(posedge clk); #1;   // pending release
        @(posedge clk); #1 check("R7", "auto gated by global", {28'd0, chan_start}, 32'd0);
        wr(12'h01C, 32'd0);
        wr(12'h040, 32'h0000_0001);
        idle(2);

        // R9 busy deferral, single pending
        wr(12'h00C, 32'h0000_0001);
        chan_busy = 4'h1;
        pulse(6'b000001);
        idle(1);
        pulse(6'b000001);
        #1 check("R9", "no start while busy", {28'd0, chan_start}, 32'd0);
        idle(2);
        #1 check("R9", "still held", {28'd0, chan_start}, 32'd0);
        chan_busy = 4'h0;
        @(posedge clk); #1 check("R9", "release on idle", {28'd0, chan_start}, 32'h1);
        @(posedge clk); #1 check("R9", "only one pending", {28'd0, chan_start}, 32'd0);
        @(posedge clk); #1 check("R9", "stays quiet", {28'd0, chan_start}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule